// File: doc/BRIEF.md
# Interrupt Enable and Mask Controller

This block holds the interrupt-enable state of a small CPU core and decides, at each instruction boundary, whether an interrupt is taken and which one. It keeps a live enable flag and a saved enable flag. The saved flag lets a non-maskable interrupt handler return with the enable state it interrupted. It also keeps a four-bit mask, one bit per maskable source. Software writes the mask with a single-port I/O output to one fixed address. Software cannot read the mask back.

The decode stage sends one-cycle strobes for the enable, disable and non-maskable-return instructions, and a pulse at each instruction boundary. The I/O write path gives the address, data, write strobe and a flag that marks block-move transfers. The block reports the winning source on a registered one-hot accept bus and as an encoded vector index. It also outputs both enable flags and the delayed-enable pending flag.

Top module: `irq_enable_ctrl`

## Requirements
- R1: After reset, both enable flags are 0, the pending flag is 0, accept_o is 0, and the mask is 4'b0001, so only the INTR source is unmasked.
- R2: The enable strobe sets both enable flags and the pending flag. The pending flag clears at the next boundary, and no maskable source is accepted at that boundary. If the enable strobe and a boundary arrive in the same cycle, the pending flag is set.
- R3: The disable strobe clears both enable flags.
- R4: An I/O write with io_blk_i low to address 0xBB loads io_data_i[3:0] into the mask. Bit 0 unmasks INTR, bit 1 unmasks RSTC, bit 2 unmasks RSTB and bit 3 unmasks RSTA.
- R5: The mask is unchanged by a write with io_blk_i high and by a write to any other address.
- R6: A maskable source is accepted only at a boundary, and only when its request is high, its mask bit is 1, both enable flags are 1 and the pending flag is 0.
- R7: Accepting the non-maskable interrupt copies the live flag into the saved flag and clears the live flag. This happens whatever the flags, the mask and the pending flag hold.
- R8: The non-maskable-return strobe copies the saved flag into the live flag and leaves the saved flag unchanged.
- R9: Accepting any maskable source clears both enable flags.
- R10: Priority, highest first, is NMI, RSTA, RSTB, RSTC, INTR. In accept_o, bit 4 is NMI, bit 3 RSTA, bit 2 RSTB, bit 1 RSTC and bit 0 INTR. vec_o gives the winner's bit index, or 0 when nothing is accepted.
- R11: A rising edge on nmi_i is held until the NMI is accepted. Only an edge seen before the boundary cycle counts. Maskable requests are sampled as levels and are not held.
- R12: accept_o and vec_o are registered. A boundary at clock edge n shows its result after edge n and holds it for one cycle. In the same cycle, an accept overrides all strobes, and among the strobes the return wins over disable, which wins over enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ei_i | input | 1 | Enable-instruction strobe |
| di_i | input | 1 | Disable-instruction strobe |
| retn_i | input | 1 | Non-maskable-return strobe |
| boundary_i | input | 1 | Instruction-boundary pulse |
| io_wr_i | input | 1 | I/O write strobe |
| io_addr_i | input | 8 | I/O port address |
| io_data_i | input | 8 | I/O write data |
| io_blk_i | input | 1 | Write belongs to a block-move output |
| nmi_i | input | 1 | Non-maskable request, edge-triggered |
| rsta_i | input | 1 | Maskable request A |
| rstb_i | input | 1 | Maskable request B |
| rstc_i | input | 1 | Maskable request C |
| intr_i | input | 1 | General maskable request |
| accept_o | output | 5 | One-hot accepted source |
| vec_o | output | 3 | Index of accepted source |
| iff1_o | output | 1 | Live enable flag |
| iff2_o | output | 1 | Saved enable flag |
| ei_pend_o | output | 1 | Delayed-enable pending flag |

## Verification
The assertions check the flag moves on every cycle. These are set-by-enable, clear-by-disable, the copy on return, the save-and-clear on NMI accept and the clear on a maskable accept. They also check that accepts are one-hot, only follow a boundary, and for maskable sources only follow an enabled, non-pending state. The mask is not visible, so the bench shows its reset value, its bit mapping and the ignored block-move and wrong-address writes only through which sources are later accepted. The bench scenarios also cover the held NMI edge, level sampling of maskable requests, the priority ordering and same-cycle strobe precedence.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned NUM_MI = 4;
  localparam int unsigned NUM_SRC = NUM_MI + 1;
  localparam int unsigned IDX_W = $clog2(NUM_SRC);

  typedef enum logic [IDX_W-1:0] {
    SRC_INTR = 3'd0,
    SRC_RSTC = 3'd1,
    SRC_RSTB = 3'd2,
    SRC_RSTA = 3'd3,
    SRC_NMI  = 3'd4
  } src_e;
endpackage

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PORT = 8'hBB,
  parameter logic [WIDTH-1:0] INIT = 4'b0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              blk_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  data_i,
  output logic [WIDTH-1:0]  mask_o
);
  logic hit;
  // only single-port output forms load the mask
  assign hit = wr_i && !blk_i && (addr_i == PORT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  mask_o <= INIT;
    else if (hit) mask_o <= data_i;
  end
endmodule

// File: rtl/irqc_nmi_latch.sv
module irqc_nmi_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic take_i,
  output logic pend_o
);
  logic nmi_d;
  logic edge_seen;

  assign edge_seen = nmi_i && !nmi_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_d  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      nmi_d  <= nmi_i;
      // a fresh edge survives a take in the same cycle
      pend_o <= edge_seen || (pend_o && !take_i);
    end
  end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int unsigned N = 5,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o
);
  // highest index wins
  for (genvar i = 0; i < N; i++) begin : g_pri
    if (i == N - 1) begin : g_top
      assign grant_o[i] = req_i[i];
    end else begin : g_low
      assign grant_o[i] = req_i[i] && !(|req_i[N-1:i+1]);
    end
  end

  always_comb begin
    idx_o = '0;
    for (int unsigned i = 0; i < N; i++) begin
      if (grant_o[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/irqc_enable_ff.sv
module irqc_enable_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ei_i,
  input  logic di_i,
  input  logic retn_i,
  input  logic boundary_i,
  input  logic take_nmi_i,
  input  logic take_mi_i,
  output logic iff1_o,
  output logic iff2_o,
  output logic pend_o
);
  logic iff1_d, iff2_d, pend_d;

  always_comb begin
    iff1_d = iff1_o;
    iff2_d = iff2_o;
    if (take_nmi_i) begin
      iff2_d = iff1_o;
      iff1_d = 1'b0;
    end else if (take_mi_i) begin
      iff1_d = 1'b0;
      iff2_d = 1'b0;
    end else if (retn_i) begin
      iff1_d = iff2_o;
    end else if (di_i) begin
      iff1_d = 1'b0;
      iff2_d = 1'b0;
    end else if (ei_i) begin
      iff1_d = 1'b1;
      iff2_d = 1'b1;
    end

    if (ei_i)            pend_d = 1'b1;
    else if (boundary_i) pend_d = 1'b0;
    else                 pend_d = pend_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iff1_o <= 1'b0;
      iff2_o <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      iff1_o <= iff1_d;
      iff2_o <= iff2_d;
      pend_o <= pend_d;
    end
  end
endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] MASK_PORT = 8'hBB,
  parameter logic [NUM_MI-1:0] MASK_INIT = 4'b0001
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ei_i,
  input  logic               di_i,
  input  logic               retn_i,
  input  logic               boundary_i,
  input  logic               io_wr_i,
  input  logic [ADDR_W-1:0]  io_addr_i,
  input  logic [DATA_W-1:0]  io_data_i,
  input  logic               io_blk_i,
  input  logic               nmi_i,
  input  logic               rsta_i,
  input  logic               rstb_i,
  input  logic               rstc_i,
  input  logic               intr_i,
  output logic [NUM_SRC-1:0] accept_o,
  output logic [IDX_W-1:0]   vec_o,
  output logic               iff1_o,
  output logic               iff2_o,
  output logic               ei_pend_o
);
  logic [NUM_MI-1:0]  mask;
  logic [NUM_MI-1:0]  mi_req;
  logic [NUM_SRC-1:0] req, grant, take;
  logic [IDX_W-1:0]   idx;
  logic               nmi_pend, mi_open;
  logic               unused_data;

  assign unused_data = ^io_data_i[DATA_W-1:NUM_MI];

  irqc_mask_reg #(
    .WIDTH (NUM_MI),
    .ADDR_W(ADDR_W),
    .PORT  (MASK_PORT),
    .INIT  (MASK_INIT)
  ) u_mask (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (io_wr_i),
    .blk_i (io_blk_i),
    .addr_i(io_addr_i),
    .data_i(io_data_i[NUM_MI-1:0]),
    .mask_o(mask)
  );

  irqc_nmi_latch u_nmi (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .nmi_i (nmi_i),
    .take_i(take[SRC_NMI]),
    .pend_o(nmi_pend)
  );

  // maskable gate: both flags, no delayed-enable window
  assign mi_open = iff1_o && iff2_o && !ei_pend_o;
  assign mi_req  = {rsta_i, rstb_i, rstc_i, intr_i} & mask & {NUM_MI{mi_open}};
  assign req     = {nmi_pend, mi_req};

  irqc_arbiter #(.N(NUM_SRC)) u_arb (
    .req_i  (req),
    .grant_o(grant),
    .idx_o  (idx)
  );

  assign take = grant & {NUM_SRC{boundary_i}};

  irqc_enable_ff u_iff (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ei_i      (ei_i),
    .di_i      (di_i),
    .retn_i    (retn_i),
    .boundary_i(boundary_i),
    .take_nmi_i(take[SRC_NMI]),
    .take_mi_i (|take[NUM_MI-1:0]),
    .iff1_o    (iff1_o),
    .iff2_o    (iff2_o),
    .pend_o    (ei_pend_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o <= '0;
      vec_o    <= '0;
    end else begin
      accept_o <= take;
      vec_o    <= (|take) ? idx : '0;
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ei_i,
  input logic               di_i,
  input logic               retn_i,
  input logic               boundary_i,
  input logic [NUM_SRC-1:0] accept_o,
  input logic [IDX_W-1:0]   vec_o,
  input logic               iff1_o,
  input logic               iff2_o,
  input logic               ei_pend_o
);
  a_r2_enable_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ei_i && !di_i && !retn_i && !boundary_i |=> iff1_o && iff2_o && ei_pend_o);

  a_r3_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    di_i && !retn_i && !boundary_i |=> !iff1_o && !iff2_o);

  a_r6_mi_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |accept_o[NUM_MI-1:0] |-> $past(iff1_o && iff2_o && !ei_pend_o));

  a_r7_nmi_save: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o[SRC_NMI] |-> !iff1_o && (iff2_o == $past(iff1_o)));

  a_r8_retn_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retn_i && !boundary_i |=> (iff1_o == $past(iff2_o)) && $stable(iff2_o));

  a_r9_mi_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |accept_o[NUM_MI-1:0] |-> !iff1_o && !iff2_o);

  a_r10_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(accept_o));

  a_r10_nmi_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o[SRC_NMI] |-> vec_o == SRC_NMI);

  a_r12_after_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |accept_o |-> $past(boundary_i));
endmodule

bind irq_enable_ctrl irqc_checker u_chk (.*);

// File: tb/irq_enable_ctrl_test.sv
module irq_enable_ctrl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ei_i = 0, di_i = 0, retn_i = 0, boundary_i = 0;
  logic       io_wr_i = 0, io_blk_i = 0;
  logic [7:0] io_addr_i = 0, io_data_i = 0;
  logic       nmi_i = 0, rsta_i = 0, rstb_i = 0, rstc_i = 0, intr_i = 0;
  logic [4:0] accept_o;
  logic [2:0] vec_o;
  logic       iff1_o, iff2_o, ei_pend_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  logic       m_iff1 = 0, m_iff2 = 0, m_pend = 0, m_nmid = 0, m_nmip = 0;
  logic [3:0] m_mask = 4'b0001;
  logic [4:0] m_acc = 0;
  logic [2:0] m_vec = 0;

  always #2 clk_i = ~clk_i;

  irq_enable_ctrl uut (.*);

  function automatic logic [4:0] pick(input logic [4:0] r);
    for (int i = 4; i >= 0; i--) if (r[i]) return 5'(1 << i);
    return 5'd0;
  endfunction

  function automatic logic [2:0] index_of(input logic [4:0] g);
    for (int i = 0; i < 5; i++) if (g[i]) return 3'(i);
    return 3'd0;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic [3:0] mreq;
    logic [4:0] g;
    logic n1, n2, np, nn;
    logic [3:0] nm;
    mreq = {rsta_i, rstb_i, rstc_i, intr_i} & m_mask & {4{m_iff1 & m_iff2 & ~m_pend}};
    g = boundary_i ? pick({m_nmip, mreq}) : 5'd0;
    n1 = m_iff1; n2 = m_iff2;
    if (g[4]) begin n2 = m_iff1; n1 = 0; end
    else if (|g[3:0]) begin n1 = 0; n2 = 0; end
    else if (retn_i) n1 = m_iff2;
    else if (di_i) begin n1 = 0; n2 = 0; end
    else if (ei_i) begin n1 = 1; n2 = 1; end
    np = ei_i ? 1'b1 : (boundary_i ? 1'b0 : m_pend);
    nn = (nmi_i & ~m_nmid) | (m_nmip & ~g[4]);
    nm = (io_wr_i && !io_blk_i && io_addr_i == 8'hBB) ? io_data_i[3:0] : m_mask;
    m_nmid = nmi_i;
    @(posedge clk_i);
    @(negedge clk_i);
    m_iff1 = n1; m_iff2 = n2; m_pend = np; m_nmip = nn; m_mask = nm;
    m_acc = g; m_vec = index_of(g);
    chk("R12 accept", 8'(accept_o), 8'(m_acc));
    chk("R10 vec", 8'(vec_o), 8'(m_vec));
    chk("R9 iff1", 8'(iff1_o), 8'(m_iff1));
    chk("R7 iff2", 8'(iff2_o), 8'(m_iff2));
    chk("R2 pend", 8'(ei_pend_o), 8'(m_pend));
    ei_i = 0; di_i = 0; retn_i = 0; boundary_i = 0; io_wr_i = 0; io_blk_i = 0;
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d, input logic blk);
    io_wr_i = 1; io_addr_i = a; io_data_i = d; io_blk_i = blk;
    tick();
  endtask

  task automatic enable_now();
    ei_i = 1; tick();
    boundary_i = 1; tick();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 iff1", 8'(iff1_o), 8'd0);
    chk("R1 iff2", 8'(iff2_o), 8'd0);
    chk("R1 pend", 8'(ei_pend_o), 8'd0);
    chk("R1 accept", 8'(accept_o), 8'd0);

    // flags off: nothing taken
    intr_i = 1; boundary_i = 1; tick();
    chk("R6 disabled", 8'(accept_o), 8'd0);

    // delayed enable
    ei_i = 1; tick();
    chk("R2 iff set", 8'({iff1_o, iff2_o, ei_pend_o}), 8'b111);
    boundary_i = 1; tick();
    chk("R2 suppressed", 8'(accept_o), 8'd0);
    chk("R2 pend cleared", 8'(ei_pend_o), 8'd0);
    boundary_i = 1; tick();
    chk("R1 intr unmasked", 8'(accept_o), 8'b00001);
    chk("R9 cleared", 8'({iff1_o, iff2_o}), 8'b00);
    intr_i = 0;

    // reset mask blocks RSTA
    enable_now();
    rsta_i = 1; boundary_i = 1; tick();
    chk("R1 rsta masked", 8'(accept_o), 8'd0);
    io_write(8'hBB, 8'h0F, 1'b1);
    boundary_i = 1; tick();
    chk("R5 block write ignored", 8'(accept_o), 8'd0);
    io_write(8'hBA, 8'h0F, 1'b0);
    boundary_i = 1; tick();
    chk("R5 other addr ignored", 8'(accept_o), 8'd0);
    io_write(8'hBB, 8'h08, 1'b0);
    boundary_i = 1; tick();
    chk("R4 rsta via bit3", 8'(accept_o), 8'b01000);
    chk("R10 rsta vec", 8'(vec_o), 8'd3);
    rsta_i = 0;

    // priority among maskables
    io_write(8'hBB, 8'h0F, 1'b0);
    enable_now();
    rstb_i = 1; rstc_i = 1; intr_i = 1; boundary_i = 1; tick();
    chk("R10 rstb wins", 8'(accept_o), 8'b00100);
    rstb_i = 0; rstc_i = 0; intr_i = 0;

    // level not held
    enable_now();
    rstc_i = 1; tick(); rstc_i = 0;
    boundary_i = 1; tick();
    chk("R11 level not held", 8'(accept_o), 8'd0);

    // NMI save and restore
    nmi_i = 1; tick(); nmi_i = 0;
    tick(); tick();
    intr_i = 1; boundary_i = 1; tick();
    chk("R7 nmi taken", 8'(accept_o), 8'b10000);
    chk("R7 iff1 cleared", 8'(iff1_o), 8'd0);
    chk("R7 iff2 saved", 8'(iff2_o), 8'd1);
    boundary_i = 1; tick();
    chk("R7 handler blocks intr", 8'(accept_o), 8'd0);
    retn_i = 1; tick();
    chk("R8 restored", 8'({iff1_o, iff2_o}), 8'b11);
    intr_i = 0;

    // same-cycle precedence
    di_i = 1; ei_i = 1; tick();
    chk("R12 di over ei", 8'({iff1_o, iff2_o}), 8'b00);
    di_i = 1; tick();
    chk("R3 disable", 8'({iff1_o, iff2_o}), 8'b00);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      ei_i       = ($urandom % 12) == 0;
      di_i       = ($urandom % 20) == 0;
      retn_i     = ($urandom % 20) == 0;
      boundary_i = ($urandom % 3) == 0;
      nmi_i      = ($urandom % 9) == 0 ? ~nmi_i : nmi_i;
      {rsta_i, rstb_i, rstc_i, intr_i} = 4'($urandom);
      io_wr_i    = ($urandom % 10) == 0;
      io_blk_i   = ($urandom % 3) == 0;
      io_addr_i  = ($urandom % 2) ? 8'hBB : 8'($urandom);
      io_data_i  = 8'($urandom);
      tick();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule